// File: doc/BRIEF.md
# Counter Clock and Gate Source Router

This block chooses, for every channel of a bank of interval counters, where that channel's count clock and its gate come from. There are three groups of counters. Each group holds two counter chips, and each chip has three channels, so the block serves eighteen channels. A host changes one channel's routing with a single byte write to one of six select registers. Each group has one register for the clock choice and one for the gate choice. The byte names the chip, the channel and a five-bit source number at the same time.

The block drives two signals per channel, both registered in the system clock domain. The first is a clock enable that pulses for one cycle for each counting event. The second is a gate level. The clock enable comes from one of three places: the channel's own external clock pin, a decade prescaler chain that makes the internal reference ticks, or a faster tick that only enhanced mode can select. External clock and gate pins pass through two synchronizing flops. The clock pin is then turned into a one-cycle pulse on each rising edge. A separate register turns enhanced mode on, and enhanced mode widens the legal source numbers from 0..7 to 0..31.

At the default parameters one system cycle lasts 25 ns. The fast tick then gives 50 ns, and prescaler outputs 1 to 5 give 100 ns, 1 µs, 10 µs, 100 µs and 1 ms.

Top module: `ctr_src_router`

## Requirements
- R1: After reset every channel has clock source 0 and gate source 0, enhanced mode is off, every gate output is 1, and no clock enable is asserted while the external clock pins stay still.
- R2: A write to byte address 0x18+g selects a clock source and a write to 0x1B+g selects a gate source, where g is 0, 1 or 2 for the three groups. Fields of the written byte: bit 5 is the chip, bits 4:3 are the channel, bits 2:0 are source[2:0] and bits 7:6 are source[4:3]. The addressed output is index 6*g + 3*chip + channel, and only that channel's routing changes.
- R3: A select write whose channel field is 3 changes no routing.
- R4: While enhanced mode is off, bits 7:6 of a select byte are stored as zero. For example, a byte that asks for source 11 stores source 3.
- R5: Writing to byte address 0x20 sets enhanced mode from bit 0 of the data. While it is set, source numbers 8 to 31 are stored in full.
- R6: Clock source 0 gives one enable pulse per rising edge of the channel's external clock pin. If the pin rises between two clock edges, the pulse is visible in the cycle after the third following edge and lasts exactly one cycle, however long the pin stays high.
- R7: Clock source k, for k from 1 to 5, gives a one-cycle enable every 2*FAST_DIV*DECADE^(k-1) cycles.
- R8: Clock source 11 gives an enable every FAST_DIV cycles while enhanced mode is on. While enhanced mode is off it gives no enable, including when the source was stored earlier.
- R9: Clock sources 6 to 10 and 12 to 31 never assert the clock enable.
- R10: Gate source 0 drives the gate to 1. Gate source 1 drives the gate to the channel's external gate pin, delayed by three clock edges. Every other gate source drives the gate to 0.
- R11: A select write takes effect at the output on the second rising edge after the write is sampled. At the first edge the output still shows the old routing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Written byte |
| ext_clk | input | NUM_GROUPS*CHIPS*CHANS | External clock pin per channel, asynchronous |
| ext_gate | input | NUM_GROUPS*CHIPS*CHANS | External gate pin per channel, asynchronous |
| ctr_clk_en | output | NUM_GROUPS*CHIPS*CHANS | Per-channel count enable, one cycle per event |
| ctr_gate | output | NUM_GROUPS*CHIPS*CHANS | Per-channel gate level |

## Verification
The bench uses a shortened prescaler so that every tick period can be measured.

Three sweeps check the address decode. The first writes a gate source that drives the gate to 0 to each of the eighteen channels in turn. The second writes clock source 1 to each channel. The third measures the period of every clock source. Together they catch a wrong group, chip or channel mapping and a wrong stage in the divider.

Every reserved source number is tried in both modes. The source-11 byte is written with enhanced mode off, then with it on, then with enhanced mode cleared afterwards. These cases separate the masking done at write time from the mode check done at the output.

Single edges and long high levels on the external pins check the synchronizer delay and that a long high level still gives only one pulse.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int SRC_W         = 5;
    localparam int CLK_SEL_BASE  = 'h18;
    localparam int GATE_SEL_BASE = 'h1B;
    localparam int ENH_ADDR      = 'h20;
    localparam int NUM_DIV       = 5;

    localparam logic [SRC_W-1:0] CLK_SRC_PIN   = 5'd0;
    localparam logic [SRC_W-1:0] CLK_SRC_FAST  = 5'd11;
    localparam logic [SRC_W-1:0] GATE_SRC_HIGH = 5'd0;
    localparam logic [SRC_W-1:0] GATE_SRC_PIN  = 5'd1;

    typedef struct packed {
        logic             chip;
        logic [1:0]       chan;
        logic [SRC_W-1:0] src;
    } sel_t;

    // Split a select byte; the upper source bits only count in enhanced mode.
    function automatic sel_t decode_sel(input logic [7:0] b, input logic enh);
        sel_t r;
        r.chip = b[5];
        r.chan = b[4:3];
        r.src  = {(enh ? b[7:6] : 2'b00), b[2:0]};
        return r;
    endfunction

endpackage

// File: rtl/csr_tick_gen.sv
module csr_tick_gen
    import csr_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int DECADE   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               fast_tick,
    output logic [NUM_DIV-1:0] div_tick
);

    localparam int FW = $clog2(FAST_DIV + 1);
    localparam int DW = $clog2(DECADE + 1);

    typedef struct packed {
        logic [FW-1:0]                fcnt;
        logic                         half;
        logic [NUM_DIV-2:0][DW-1:0]   dcnt;
    } tick_t;

    tick_t st_d, st_q;

    always_comb begin
        logic [NUM_DIV-1:0] t;
        logic               f;
        st_d = st_q;
        f    = (st_q.fcnt == FW'(FAST_DIV - 1));
        st_d.fcnt = f ? '0 : st_q.fcnt + 1'b1;
        if (f) st_d.half = ~st_q.half;
        t    = '0;
        t[0] = f & st_q.half;
        for (int k = 1; k < NUM_DIV; k++) begin
            t[k] = t[k-1] & (st_q.dcnt[k-1] == DW'(DECADE - 1));
            if (t[k-1])
                st_d.dcnt[k-1] = t[k] ? '0 : st_q.dcnt[k-1] + 1'b1;
        end
        fast_tick = f;
        div_tick  = t;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/csr_pin_sync.sv
module csr_pin_sync #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        level   = st_q.s2;
        rise    = st_q.s2 & ~st_q.s3;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/csr_src_mux.sv
module csr_src_mux
    import csr_pkg::*;
#(
    parameter int NUM_CH = 18
) (
    input  logic [NUM_CH-1:0][SRC_W-1:0] clk_src,
    input  logic [NUM_CH-1:0][SRC_W-1:0] gate_src,
    input  logic                         enh,
    input  logic                         fast_tick,
    input  logic [NUM_DIV-1:0]           div_tick,
    input  logic [NUM_CH-1:0]            pin_rise,
    input  logic [NUM_CH-1:0]            gate_level,
    output logic [NUM_CH-1:0]            clk_sel,
    output logic [NUM_CH-1:0]            gate_sel
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_comb begin
            clk_sel[i] = 1'b0;
            if (clk_src[i] == CLK_SRC_PIN)
                clk_sel[i] = pin_rise[i];
            else if (clk_src[i] == CLK_SRC_FAST)
                clk_sel[i] = enh & fast_tick;
            for (int k = 0; k < NUM_DIV; k++)
                if (clk_src[i] == SRC_W'(k + 1))
                    clk_sel[i] = div_tick[k];
        end

        always_comb begin
            if (gate_src[i] == GATE_SRC_HIGH)
                gate_sel[i] = 1'b1;
            else if (gate_src[i] == GATE_SRC_PIN)
                gate_sel[i] = gate_level[i];
            else
                gate_sel[i] = 1'b0;
        end
    end

endmodule

// File: rtl/ctr_src_router.sv
module ctr_src_router
    import csr_pkg::*;
#(
    parameter int NUM_GROUPS = 3,
    parameter int CHIPS      = 2,
    parameter int CHANS      = 3,
    parameter int FAST_DIV   = 2,
    parameter int DECADE     = 10,
    parameter int ADDR_W     = 6
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [7:0]                          wr_data,
    input  logic [NUM_GROUPS*CHIPS*CHANS-1:0]   ext_clk,
    input  logic [NUM_GROUPS*CHIPS*CHANS-1:0]   ext_gate,
    output logic [NUM_GROUPS*CHIPS*CHANS-1:0]   ctr_clk_en,
    output logic [NUM_GROUPS*CHIPS*CHANS-1:0]   ctr_gate
);

    localparam int PER_GROUP = CHIPS * CHANS;
    localparam int NUM_CH    = NUM_GROUPS * PER_GROUP;

    typedef struct packed {
        logic [NUM_CH-1:0][SRC_W-1:0] clk_src;
        logic [NUM_CH-1:0][SRC_W-1:0] gate_src;
        logic                         enh;
        logic [NUM_CH-1:0]            clk_en;
        logic [NUM_CH-1:0]            gate;
    } state_t;

    state_t st_d, st_q;

    logic               fast_tick;
    logic [NUM_DIV-1:0] div_tick;
    logic [NUM_CH-1:0]  clk_rise, clk_level_unused_n;
    logic [NUM_CH-1:0]  gate_level, gate_rise_unused_n;
    logic [NUM_CH-1:0]  clk_sel, gate_sel;

    csr_tick_gen #(.FAST_DIV(FAST_DIV), .DECADE(DECADE)) u_ticks (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_tick (fast_tick),
        .div_tick  (div_tick)
    );

    csr_pin_sync #(.W(NUM_CH)) u_clk_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk),
        .level (clk_level_unused_n),
        .rise  (clk_rise)
    );

    csr_pin_sync #(.W(NUM_CH)) u_gate_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_gate),
        .level (gate_level),
        .rise  (gate_rise_unused_n)
    );

    csr_src_mux #(.NUM_CH(NUM_CH)) u_mux (
        .clk_src    (st_q.clk_src),
        .gate_src   (st_q.gate_src),
        .enh        (st_q.enh),
        .fast_tick  (fast_tick),
        .div_tick   (div_tick),
        .pin_rise   (clk_rise),
        .gate_level (gate_level),
        .clk_sel    (clk_sel),
        .gate_sel   (gate_sel)
    );

    always_comb begin
        sel_t sel;
        st_d = st_q;
        sel  = decode_sel(wr_data, st_q.enh);
        if (wr_en && wr_addr == ADDR_W'(ENH_ADDR))
            st_d.enh = wr_data[0];
        for (int g = 0; g < NUM_GROUPS; g++) begin
            for (int c = 0; c < CHIPS; c++) begin
                for (int h = 0; h < CHANS; h++) begin
                    if (wr_en && sel.chip == 1'(c) && sel.chan == 2'(h)) begin
                        if (wr_addr == ADDR_W'(CLK_SEL_BASE + g))
                            st_d.clk_src[g*PER_GROUP + c*CHANS + h] = sel.src;
                        if (wr_addr == ADDR_W'(GATE_SEL_BASE + g))
                            st_d.gate_src[g*PER_GROUP + c*CHANS + h] = sel.src;
                    end
                end
            end
        end
        st_d.clk_en = clk_sel;
        st_d.gate   = gate_sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.gate <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctr_clk_en = st_q.clk_en;
    assign ctr_gate   = st_q.gate;

endmodule

// File: rtl/csr_checks.sv
module csr_checks
    import csr_pkg::*;
#(
    parameter int NUM_CH = 18,
    parameter int ADDR_W = 6
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [1:0]                   wr_chan,
    input logic [NUM_CH-1:0][SRC_W-1:0] clk_src,
    input logic [NUM_CH-1:0][SRC_W-1:0] gate_src,
    input logic                         enh,
    input logic [NUM_CH-1:0]            ctr_clk_en,
    input logic [NUM_CH-1:0]            ctr_gate
);

    logic sel_write;
    logic has_high;
    logic [NUM_CH-1:0] res_clk, res_gate;

    always_comb begin
        sel_write = wr_en && (int'(wr_addr) >= CLK_SEL_BASE) &&
                    (int'(wr_addr) < GATE_SEL_BASE + 3);
        has_high = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            has_high    = has_high | (|clk_src[i][4:3]) | (|gate_src[i][4:3]);
            res_clk[i]  = (clk_src[i] > 5'd5) && !(clk_src[i] == CLK_SRC_FAST && enh);
            res_gate[i] = (gate_src[i] > GATE_SRC_PIN);
        end
    end

    // R1: gates come up high on the first cycle out of reset
    assert_reset_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (&ctr_gate));

    // R3: channel field 3 leaves all routing untouched
    assert_chan3_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_write && wr_chan == 2'd3) |=> ($stable(clk_src) && $stable(gate_src)));

    // R4: upper source bits cannot appear while enhanced mode stays off
    assert_no_high_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh && !has_high) |=> !has_high);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // R9, R8: a reserved or disabled clock source gives no enable
        assert_reserved_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
            $past(res_clk[i]) |-> !ctr_clk_en[i]);
        // R10: gate source 0 forces the gate high
        assert_gate_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(gate_src[i] == GATE_SRC_HIGH) |-> ctr_gate[i]);
        // R10: other unused gate sources force the gate low
        assert_gate_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(res_gate[i]) |-> !ctr_gate[i]);
    end

endmodule

bind ctr_src_router csr_checks #(
    .NUM_CH (NUM_GROUPS*CHIPS*CHANS),
    .ADDR_W (ADDR_W)
) u_csr_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_chan    (wr_data[4:3]),
    .clk_src    (st_q.clk_src),
    .gate_src   (st_q.gate_src),
    .enh        (st_q.enh),
    .ctr_clk_en (ctr_clk_en),
    .ctr_gate   (ctr_gate)
);

// File: tb/test_ctr_src_router.sv
module test_ctr_src_router;

    localparam int NCH = 18;
    localparam int FD  = 2;
    localparam int DEC = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [5:0]      wr_addr = '0;
    logic [7:0]      wr_data = '0;
    logic [NCH-1:0]  ext_clk = '0;
    logic [NCH-1:0]  ext_gate = '0;
    logic [NCH-1:0]  clk_en;
    logic [NCH-1:0]  gate;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    ctr_src_router #(.FAST_DIV(FD), .DECADE(DEC)) i_ctr_src_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .ext_clk    (ext_clk),
        .ext_gate   (ext_gate),
        .ctr_clk_en (clk_en),
        .ctr_gate   (gate)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input int chip, input int chan, input int src);
        logic [4:0] s;
        logic [1:0] h;
        logic [0:0] c;
        s = 5'(src);
        h = 2'(chan);
        c = 1'(chip);
        return {s[4:3], c, h, s[2:0]};
    endfunction

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 6'(a);
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // Cycles between two consecutive enables on channel ch, -1 if none.
    task automatic measure(input int ch, output int per);
        int n;
        per = -1;
        n = 0;
        while (n < 2000 && !clk_en[ch]) begin
            @(negedge clk);
            n++;
        end
        if (clk_en[ch]) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (n < 2000 && !clk_en[ch]);
            if (clk_en[ch]) per = n;
        end
    endtask

    task automatic quiet(input int ch, input int cycles, output int hits);
        hits = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (clk_en[ch]) hits++;
        end
    endtask

    function automatic int grp(input int ch); return ch / 6; endfunction
    function automatic int chp(input int ch); return (ch / 3) % 2; endfunction
    function automatic int chn(input int ch); return ch % 3; endfunction

    task automatic set_clk(input int ch, input int src);
        wr('h18 + grp(ch), mk(chp(ch), chn(ch), src));
        settle();
    endtask

    task automatic set_gate(input int ch, input int src);
        wr('h1B + grp(ch), mk(chp(ch), chn(ch), src));
        settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int per, hits, exp_per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(gate == '1, "R1 gates high", int'(gate), int'({NCH{1'b1}}));
        quiet(0, 20, hits);
        check(clk_en == '0 && hits == 0, "R1 no enables", hits, 0);

        // R2, R11: gate sweep over every channel, with latency on each
        for (int ch = 0; ch < NCH; ch++) begin
            wr('h1B + grp(ch), mk(chp(ch), chn(ch), 2));
            check(gate == '1, "R11 old routing after first edge", int'(gate), int'({NCH{1'b1}}));
            @(negedge clk);
            check(gate == ~(NCH'(1) << ch), "R2 gate decode", int'(gate), int'(~(NCH'(1) << ch)));
            set_gate(ch, 0);
        end

        // R3: channel field 3 changes nothing
        for (int g = 0; g < 3; g++) begin
            wr('h1B + g, 8'b00_0_11_010);
            wr('h18 + g, 8'b00_1_11_010);
            settle();
            check(gate == '1, "R3 chan 3 gate", int'(gate), int'({NCH{1'b1}}));
            quiet(g * 6, 40, hits);
            check(hits == 0, "R3 chan 3 clock", hits, 0);
        end

        // R2, R7: clock source 1 on every channel
        for (int ch = 0; ch < NCH; ch++) begin
            set_clk(ch, 1);
            measure(ch, per);
            check(per == 2 * FD, "R2 R7 clock decode src1", per, 2 * FD);
            set_clk(ch, 0);
        end

        // R7: each prescaler stage
        exp_per = 2 * FD;
        for (int k = 1; k <= 5; k++) begin
            set_clk(7, k);
            measure(7, per);
            check(per == exp_per, "R7 stage period", per, exp_per);
            exp_per = exp_per * DEC;
        end

        // R4: normal mode drops the upper bits (11 -> 3)
        set_clk(7, 11);
        measure(7, per);
        check(per == 2 * FD * DEC * DEC, "R4 masked source", per, 2 * FD * DEC * DEC);
        set_gate(5, 8);
        check(gate[5] == 1'b1, "R4 gate 8 masked to 0", int'(gate[5]), 1);

        // R9: reserved sources in normal mode
        for (int s = 6; s <= 7; s++) begin
            set_clk(13, s);
            quiet(13, 400, hits);
            check(hits == 0, "R9 reserved normal", hits, 0);
        end

        // R5, R8: enhanced mode
        wr('h20, 8'h01);
        set_gate(5, 8);
        check(gate[5] == 1'b0, "R5 gate 8 stored", int'(gate[5]), 0);
        set_gate(5, 0);
        set_clk(7, 11);
        measure(7, per);
        check(per == FD, "R8 fast tick", per, FD);

        // R9: every reserved source in enhanced mode
        for (int s = 6; s <= 31; s++) begin
            if (s != 11) begin
                set_clk(13, s);
                quiet(13, 40, hits);
                check(hits == 0, "R9 reserved enhanced", hits, s * 0);
            end
        end
        set_clk(13, 0);

        // R8: clearing enhanced mode silences a stored source 11
        wr('h20, 8'h00);
        settle();
        quiet(7, 400, hits);
        check(hits == 0, "R8 src11 off in normal mode", hits, 0);
        set_clk(7, 0);

        // R6: external clock pin timing
        @(negedge clk);
        ext_clk[9] = 1'b1;
        @(negedge clk); check(clk_en[9] == 1'b0, "R6 edge1", int'(clk_en[9]), 0);
        @(negedge clk); check(clk_en[9] == 1'b0, "R6 edge2", int'(clk_en[9]), 0);
        @(negedge clk); check(clk_en[9] == 1'b1, "R6 edge3 pulse", int'(clk_en[9]), 1);
        @(negedge clk); check(clk_en[9] == 1'b0, "R6 single cycle", int'(clk_en[9]), 0);
        quiet(9, 20, hits);
        check(hits == 0, "R6 held high", hits, 0);
        ext_clk[9] = 1'b0;
        settle();

        // R10: gate from the external pin and fixed levels
        set_gate(4, 1);
        ext_gate[4] = 1'b1;
        repeat (2) @(negedge clk);
        check(gate[4] == 1'b0, "R10 pin delay", int'(gate[4]), 0);
        @(negedge clk);
        check(gate[4] == 1'b1, "R10 pin high", int'(gate[4]), 1);
        ext_gate[4] = 1'b0;
        repeat (3) @(negedge clk);
        check(gate[4] == 1'b0, "R10 pin low", int'(gate[4]), 0);
        set_gate(4, 3);
        ext_gate[4] = 1'b1;
        settle();
        check(gate[4] == 1'b0, "R10 other gate source", int'(gate[4]), 0);
        set_gate(4, 0);
        check(gate[4] == 1'b1, "R10 gate source 0", int'(gate[4]), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule